// File: doc/BRIEF.md
# Quantization Widening Trigger

This block watches a layered low-density parity-check decoder as it converges and decides, at most once per codeword, when to halve every stored message so that the same message width covers twice the range. After each layer the check-node units each report one flag. The flag is high when the signs of all the variable messages entering that check node multiply to a negative value. The block counts the raised flags for the layer and adds that count to the counts of the layers just before it. When the total over the most recent `l` layers falls below a programmable threshold, the block raises a one-cycle apply pulse. Surrounding logic uses that pulse to arithmetic-shift all posterior and check-node messages right by one bit, starting with the next layer. A sticky scale-down output stays high until the next codeword starts.

When two layers run together, each unit presents two flags, and the block counts a unit as raised if either flag is high. The window length and the threshold are run-time inputs. The block does not form the sign products and does not shift any message store.

Top module: `quant_widen_ctrl`

## Requirements
- R1: After reset, `scale_down` and `apply_pulse` are both 0.
- R2: The per-layer count is the number of units whose flag is set. When `pair_mode` is 1, a unit's flag is `flag_a[i] | flag_b[i]`. When `pair_mode` is 0, only `flag_a[i]` counts and `flag_b` has no effect.
- R3: The window total is the sum of the counts of the current layer and the `l-1` layers before it within the codeword. Older layers drop out of the total. The total is exact up to `l` = 12 with all 96 flags set (1152).
- R4: A `layer_done` sampled at a clock edge, with a window total strictly less than `thresh`, causes `apply_pulse` and `scale_down` to be high after that same edge.
- R5: No trigger occurs until at least `l` layers have completed since the last codeword start.
- R6: At most one apply pulse per codeword. `scale_down` stays 1 until `cw_start`.
- R7: `cw_start` clears the window, the layer tally and `scale_down`. A `layer_done` in the same cycle as `cw_start` is ignored.
- R8: A window total equal to `thresh` does not trigger.
- R9: A `win_len` of 0 acts as a window of 1 layer. A `win_len` above 12 acts as a window of 12 layers.
- R10: `apply_pulse` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_start | input | 1 | Start of a new codeword; clears all state |
| layer_done | input | 1 | Flags are valid and a layer has finished |
| pair_mode | input | 1 | Two layers run together; OR the two flags of each unit |
| flag_a | input | 96 | Negative-sign-product flag per unit (first layer) |
| flag_b | input | 96 | Negative-sign-product flag per unit (second layer, pair mode only) |
| win_len | input | 4 | Window length `l` in layers |
| thresh | input | 11 | Trigger threshold on the window total |
| scale_down | output | 1 | Sticky: messages have been halved in this codeword |
| apply_pulse | output | 1 | One-cycle command to shift all messages right by one bit |

## Verification
A wrong layer count or a dropped window entry shows up as a trigger that fires one layer early or late. It can also show up as a trigger that fires at a threshold it should miss, or misses one it should hit. Each of these is visible on `apply_pulse` one edge after the offending `layer_done`. The tests therefore place the threshold exactly at the expected total and one above it, so that an off-by-one in counting, window length or comparison flips the result. A tally that survives `cw_start` appears as a pulse before `l` fresh layers have completed. A broken sticky flag appears as a second pulse, or as `scale_down` dropping, within the same codeword.

// File: rtl/quant_widen_ctrl.sv
module quant_widen_ctrl #(
  parameter int UNITS   = 96,
  parameter int MAX_WIN = 12,
  localparam int CW = $clog2(UNITS + 1),
  localparam int SW = $clog2(MAX_WIN * UNITS + 1),
  localparam int LW = $clog2(MAX_WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cw_start,
  input  logic             layer_done,
  input  logic             pair_mode,
  input  logic [UNITS-1:0] flag_a,
  input  logic [UNITS-1:0] flag_b,
  input  logic [LW-1:0]    win_len,
  input  logic [SW-1:0]    thresh,
  output logic             scale_down,
  output logic             apply_pulse
);

  logic [UNITS-1:0] eff;
  logic [CW-1:0]    layer_cnt;
  logic [CW-1:0]    hist [MAX_WIN];
  logic [LW-1:0]    seen, seen_nxt, l_eff;
  logic [SW-1:0]    win_sum;
  logic             fire;

  assign eff = pair_mode ? (flag_a | flag_b) : flag_a;

  always_comb begin
    layer_cnt = '0;
    for (int i = 0; i < UNITS; i++) layer_cnt = layer_cnt + CW'(eff[i]);
  end

  assign l_eff = (win_len == '0) ? LW'(1) :
                 (win_len > LW'(MAX_WIN)) ? LW'(MAX_WIN) : win_len;

  always_comb begin
    win_sum = SW'(layer_cnt);
    for (int i = 1; i < MAX_WIN; i++)
      if (LW'(i) < l_eff) win_sum = win_sum + SW'(hist[i-1]);
  end

  assign seen_nxt = (seen == LW'(MAX_WIN)) ? seen : seen + LW'(1);
  assign fire = layer_done && !cw_start && !scale_down &&
                (seen_nxt >= l_eff) && (win_sum < thresh);

  always_ff @(posedge clk) begin
    if (!rst_n || cw_start) begin
      seen        <= '0;
      scale_down  <= 1'b0;
      apply_pulse <= 1'b0;
      for (int i = 0; i < MAX_WIN; i++) hist[i] <= '0;
    end else begin
      apply_pulse <= fire;
      if (fire) scale_down <= 1'b1;
      if (layer_done) begin
        seen    <= seen_nxt;
        hist[0] <= layer_cnt;
        for (int i = 1; i < MAX_WIN; i++) hist[i] <= hist[i-1];
      end
    end
  end

endmodule

// File: rtl/quant_widen_ctrl_chk.sv
module quant_widen_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cw_start,
  input logic layer_done,
  input logic scale_down,
  input logic apply_pulse
);

  p_pulse_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |=> !apply_pulse);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_down && !cw_start) |=> scale_down);

  p_single_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_down && !cw_start) |=> !apply_pulse);

  p_pulse_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |-> scale_down);

  p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply_pulse |-> ($past(layer_done) && !$past(cw_start)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cw_start |=> (!scale_down && !apply_pulse));

endmodule

bind quant_widen_ctrl quant_widen_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cw_start(cw_start), .layer_done(layer_done),
  .scale_down(scale_down), .apply_pulse(apply_pulse)
);

// File: tb/tb_quant_widen_ctrl.sv
module tb_quant_widen_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int U = 96;

  logic clk = 0, rst_n = 0, cw_start = 0, layer_done = 0, pair_mode = 0;
  logic [U-1:0] flag_a = '0, flag_b = '0;
  logic [3:0]  win_len = 4'd1;
  logic [10:0] thresh = '0;
  logic scale_down, apply_pulse;
  int n_chk = 0, n_fail = 0;

  quant_widen_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [U-1:0] ones(int k);
    logic [U-1:0] m = '0;
    for (int i = 0; i < k; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic new_cw();
    @(negedge clk); cw_start = 1;
    @(negedge clk); cw_start = 0;
  endtask

  task automatic run_layer(logic [U-1:0] a, logic [U-1:0] b, bit exp, string req);
    @(negedge clk); layer_done = 1; flag_a = a; flag_b = b;
    @(negedge clk); layer_done = 0;
    check(apply_pulse == exp, req, apply_pulse, exp);
  endtask

  task automatic t_reset();
    check(scale_down == 0 && apply_pulse == 0, "R1", {scale_down, apply_pulse}, 0);
  endtask

  task automatic t_count();
    pair_mode = 0; win_len = 1;
    new_cw(); thresh = 21; run_layer(ones(20), '0, 1, "R2 single count 20 < 21");
    new_cw(); thresh = 20; run_layer(ones(20), '0, 0, "R8 total equals threshold");
    pair_mode = 1;
    new_cw(); thresh = 35; run_layer(ones(10), ones(35) & ~ones(5), 0, "R2 pair OR count 35");
    new_cw(); thresh = 36; run_layer(ones(10), ones(35) & ~ones(5), 1, "R2 pair OR count 35 < 36");
    pair_mode = 0;
    new_cw(); thresh = 11; run_layer(ones(10), ones(35) & ~ones(5), 1, "R2 flag_b ignored");
  endtask

  task automatic t_warmup_once();
    win_len = 4; thresh = 1000;
    new_cw();
    for (int i = 0; i < 3; i++) run_layer('0, '0, 0, "R5 warm-up");
    run_layer('0, '0, 1, "R4 fires on layer l");
    check(scale_down == 1, "R4 scale_down set", scale_down, 1);
    @(negedge clk);
    check(apply_pulse == 0, "R10 pulse one cycle", apply_pulse, 0);
    for (int i = 0; i < 3; i++) run_layer('0, '0, 0, "R6 no second pulse");
    check(scale_down == 1, "R6 sticky", scale_down, 1);
  endtask

  task automatic t_clear();
    new_cw();
    check(scale_down == 0, "R7 cleared", scale_down, 0);
    win_len = 4; thresh = 1000;
    run_layer('0, '0, 0, "R7 window restarted");
    win_len = 1;
    @(negedge clk); cw_start = 1; layer_done = 1; flag_a = '0;
    @(negedge clk); cw_start = 0; layer_done = 0;
    check(apply_pulse == 0 && scale_down == 0, "R7 priority", apply_pulse, 0);
    win_len = 2;
    run_layer('0, '0, 0, "R7 simultaneous layer not counted");
    run_layer('0, '0, 1, "R7 second layer fires");
  endtask

  task automatic t_slide();
    win_len = 2; thresh = 100; new_cw();
    run_layer(ones(60), '0, 0, "R5 slide warm-up");
    run_layer(ones(60), '0, 0, "R3 total 120");
    run_layer(ones(30), '0, 1, "R3 oldest dropped total 90");
  endtask

  task automatic t_wide();
    win_len = 12; thresh = 1152; new_cw();
    for (int i = 0; i < 12; i++) run_layer(ones(U), '0, 0, "R3 total 1152 not below 1152");
    thresh = 1153; new_cw();
    for (int i = 0; i < 11; i++) run_layer(ones(U), '0, 0, "R5 wide warm-up");
    run_layer(ones(U), '0, 1, "R3 total 1152 below 1153");
  endtask

  task automatic t_clamp();
    win_len = 0; thresh = 5; new_cw();
    run_layer('0, '0, 1, "R9 zero acts as one");
    win_len = 15; thresh = 1000; new_cw();
    for (int i = 0; i < 11; i++) run_layer('0, '0, 0, "R9 clamp warm-up");
    run_layer('0, '0, 1, "R9 clamped to 12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_warmup_once();
    t_clear();
    t_slide();
    t_wide();
    t_clamp();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule